// File: doc/BRIEF.md
# Lockstep Core Bus Comparator

This block joins two identical processor cores, running in strict cycle lockstep, to one system bus. The primary core alone drives the bus: its address, write data, write enable and control lines pass straight through to memory. The shadow core's outputs go nowhere except into a comparator. Read data and the bus ready signal coming back from memory are fanned out unchanged to both cores, so the shadow core sees exactly the stream the primary fetched.

The comparator checks three groups of signals on every clock: address, write data and control. The control group includes the write enable. Write data is checked only on cycles where the primary core is writing. Address and control are checked on every cycle. Any differing bit raises one sticky fault flag, registered one clock after the mismatch. The flag does not say which core is at fault. On the first mismatching cycle a three-bit group status is captured and then held, to help with diagnosis. A test input inverts one bit of the shadow address path, so that software or a production test can prove the comparator still detects faults.

The bus handshake is valid/ready and is passed through untouched. `pri_ctrl[0]` is the request valid. The primary core holds its request and payload stable until it sees `pri_ready`. Back-pressure from `bus_ready` reaches both cores in the same cycle, so the two cores stall together and stay in lockstep.

Top module: `lockstep_cmp`

## Requirements
- R1: `bus_addr`, `bus_wdata`, `bus_ctrl` and `bus_we` equal the primary core's `pri_addr`, `pri_wdata`, `pri_ctrl` and `pri_we` in the same cycle, whatever the shadow core drives.
- R2: `pri_rdata` and `shd_rdata` both equal `bus_rdata`, and `pri_ready` and `shd_ready` both equal `bus_ready`, in the same cycle.
- R3: A difference in any bit of the address between the two cores raises `fault` after the next rising clock edge and sets status bit 0 (address group).
- R4: Write data is compared only when `pri_we` is 1. A write-data difference sets status bit 1 (data group). A difference while `pri_we` is 0 leaves `fault` low.
- R5: A difference in any bit of `ctrl`, or in the write enable, is detected on every cycle and sets status bit 2 (control group).
- R6: Once `fault` is high it stays high until `rst_n` is low, even when the cores agree again.
- R7: `fault_grp` holds the set of groups that mismatched in the first faulting cycle, with several bits set if several groups differed. Later mismatches in other groups leave it unchanged.
- R8: With `inject` high, shadow address bit 0 is inverted before comparison, so cores that agree raise `fault` with `fault_grp` = 3'b001.
- R9: While `rst_n` is low, and after reset, `fault` is 0 and `fault_grp` is 3'b000.
- R10: A mismatch never raises `fault` in its own cycle. `fault` rises exactly one clock edge later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| inject | input | 1 | Test: invert shadow address bit 0 before comparison |
| pri_addr | input | AW | Primary core address |
| pri_wdata | input | DW | Primary core write data |
| pri_ctrl | input | CW | Primary core control; bit 0 is request valid |
| pri_we | input | 1 | Primary core write enable |
| shd_addr | input | AW | Shadow core address |
| shd_wdata | input | DW | Shadow core write data |
| shd_ctrl | input | CW | Shadow core control |
| shd_we | input | 1 | Shadow core write enable |
| bus_addr | output | AW | Address to system bus |
| bus_wdata | output | DW | Write data to system bus |
| bus_ctrl | output | CW | Control to system bus |
| bus_we | output | 1 | Write enable to system bus |
| bus_rdata | input | DW | Read data or instruction from memory |
| bus_ready | input | 1 | Bus ready (back-pressure) |
| pri_rdata | output | DW | Read data to primary core |
| pri_ready | output | 1 | Ready to primary core |
| shd_rdata | output | DW | Read data to shadow core |
| shd_ready | output | 1 | Ready to shadow core |
| fault | output | 1 | Sticky lockstep disagreement flag |
| fault_grp | output | 3 | Groups mismatched in the first faulting cycle: bit0 address, bit1 data, bit2 control |

## Verification
The assertions assume the cores' outputs are known, not X, on every cycle after reset. They also assume reset is held for at least one clock, so that the sticky state starts clean. The stimulus always drives fully defined values. It changes inputs only on the falling edge, and it uses one reset pulse of several cycles before each directed scenario. Matching traffic is randomised, while every mismatch is placed deliberately, so each group, the write-enable qualifier and the test inversion are each hit in isolation and in combination.

// File: rtl/lsc_pkg.sv
package lsc_pkg;
  localparam int NGRP = 3;
  typedef enum int unsigned {
    GRP_ADDR = 0,
    GRP_DATA = 1,
    GRP_CTRL = 2
  } grp_e;
endpackage

// File: rtl/lsc_fwd.sv
module lsc_fwd #(
  parameter int AW = 32,
  parameter int DW = 32,
  parameter int CW = 4,
  parameter int INJ_BIT = 0
) (
  input  logic          inject,
  input  logic [AW-1:0] pri_addr,
  input  logic [DW-1:0] pri_wdata,
  input  logic [CW-1:0] pri_ctrl,
  input  logic          pri_we,
  input  logic [AW-1:0] shd_addr,
  output logic [AW-1:0] shd_addr_chk,
  output logic [AW-1:0] bus_addr,
  output logic [DW-1:0] bus_wdata,
  output logic [CW-1:0] bus_ctrl,
  output logic          bus_we,
  input  logic [DW-1:0] bus_rdata,
  input  logic          bus_ready,
  output logic [DW-1:0] pri_rdata,
  output logic          pri_ready,
  output logic [DW-1:0] shd_rdata,
  output logic          shd_ready
);
  localparam logic [AW-1:0] INJ_MASK = {{(AW-1){1'b0}}, 1'b1} << INJ_BIT;

  // Only the primary core reaches the bus.
  assign bus_addr  = pri_addr;
  assign bus_wdata = pri_wdata;
  assign bus_ctrl  = pri_ctrl;
  assign bus_we    = pri_we;

  // Returning data is shared so both cores execute the same stream.
  assign pri_rdata = bus_rdata;
  assign shd_rdata = bus_rdata;
  assign pri_ready = bus_ready;
  assign shd_ready = bus_ready;

  // Test inversion on the shadow comparison path.
  assign shd_addr_chk = inject ? (shd_addr ^ INJ_MASK) : shd_addr;
endmodule

// File: rtl/lsc_diff.sv
module lsc_diff #(
  parameter int W = 32
) (
  input  logic         en,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic         mis
);
  logic [W-1:0] bitdiff;

  for (genvar i = 0; i < W; i++) begin : g_bit
    assign bitdiff[i] = a[i] ^ b[i];
  end

  assign mis = en & (|bitdiff);
endmodule

// File: rtl/lsc_latch.sv
module lsc_latch
  import lsc_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NGRP-1:0] mis,
  output logic            fault,
  output logic [NGRP-1:0] fault_grp
);
  logic any_mis;
  assign any_mis = |mis;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fault     <= 1'b0;
      fault_grp <= '0;
    end else begin
      if (!fault && any_mis) fault_grp <= mis;
      if (any_mis) fault <= 1'b1;
    end
  end

  assert_mis_flags_R10: assert property (@(posedge clk) disable iff (!rst_n)
    any_mis |=> fault);
  assert_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
    fault |=> fault);
  assert_grp_frozen_R7: assert property (@(posedge clk) disable iff (!rst_n)
    fault |=> $stable(fault_grp));
  assert_grp_first_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fault) |-> fault_grp == $past(mis));
  assert_clean_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !fault |-> fault_grp == '0);
  assert_grp_set_R3: assert property (@(posedge clk) disable iff (!rst_n)
    fault |-> $countones(fault_grp) > 0);
endmodule

// File: rtl/lockstep_cmp.sv
module lockstep_cmp
  import lsc_pkg::*;
#(
  parameter int AW = 32,
  parameter int DW = 32,
  parameter int CW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          inject,
  input  logic [AW-1:0] pri_addr,
  input  logic [DW-1:0] pri_wdata,
  input  logic [CW-1:0] pri_ctrl,
  input  logic          pri_we,
  input  logic [AW-1:0] shd_addr,
  input  logic [DW-1:0] shd_wdata,
  input  logic [CW-1:0] shd_ctrl,
  input  logic          shd_we,
  output logic [AW-1:0] bus_addr,
  output logic [DW-1:0] bus_wdata,
  output logic [CW-1:0] bus_ctrl,
  output logic          bus_we,
  input  logic [DW-1:0] bus_rdata,
  input  logic          bus_ready,
  output logic [DW-1:0] pri_rdata,
  output logic          pri_ready,
  output logic [DW-1:0] shd_rdata,
  output logic          shd_ready,
  output logic          fault,
  output logic [2:0]    fault_grp
);
  localparam int CTW = CW + 1;

  logic [AW-1:0]   shd_addr_chk;
  logic [NGRP-1:0] mis;

  lsc_fwd #(.AW(AW), .DW(DW), .CW(CW), .INJ_BIT(0)) u_fwd (
    .inject(inject), .pri_addr(pri_addr), .pri_wdata(pri_wdata),
    .pri_ctrl(pri_ctrl), .pri_we(pri_we), .shd_addr(shd_addr),
    .shd_addr_chk(shd_addr_chk), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_ctrl(bus_ctrl), .bus_we(bus_we), .bus_rdata(bus_rdata),
    .bus_ready(bus_ready), .pri_rdata(pri_rdata), .pri_ready(pri_ready),
    .shd_rdata(shd_rdata), .shd_ready(shd_ready)
  );

  lsc_diff #(.W(AW)) u_addr (
    .en(1'b1), .a(pri_addr), .b(shd_addr_chk), .mis(mis[GRP_ADDR])
  );

  // Write data only matters while the primary is writing.
  lsc_diff #(.W(DW)) u_data (
    .en(pri_we), .a(pri_wdata), .b(shd_wdata), .mis(mis[GRP_DATA])
  );

  lsc_diff #(.W(CTW)) u_ctrl (
    .en(1'b1), .a({pri_we, pri_ctrl}), .b({shd_we, shd_ctrl}), .mis(mis[GRP_CTRL])
  );

  lsc_latch u_latch (
    .clk(clk), .rst_n(rst_n), .mis(mis), .fault(fault), .fault_grp(fault_grp)
  );

  assert_write_gate_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!pri_we && !fault && pri_addr == shd_addr_chk &&
     {pri_we, pri_ctrl} == {shd_we, shd_ctrl}) |=> !fault);
endmodule

// File: tb/sim_lockstep_cmp.sv
module sim_lockstep_cmp;
  localparam int AW = 32, DW = 32, CW = 4;

  logic clk = 0, rst_n = 0, inject = 0;
  logic [AW-1:0] pri_addr = 0, shd_addr = 0;
  logic [DW-1:0] pri_wdata = 0, shd_wdata = 0, bus_rdata = 0;
  logic [CW-1:0] pri_ctrl = 0, shd_ctrl = 0;
  logic pri_we = 0, shd_we = 0, bus_ready = 0;
  logic [AW-1:0] bus_addr;
  logic [DW-1:0] bus_wdata, pri_rdata, shd_rdata;
  logic [CW-1:0] bus_ctrl;
  logic bus_we, pri_ready, shd_ready, fault;
  logic [2:0] fault_grp;

  int vectors = 0, fails = 0, cycles = 0;
  bit m_fault = 0;
  logic [2:0] m_grp = 0;

  always #5 clk = ~clk;

  lockstep_cmp #(.AW(AW), .DW(DW), .CW(CW)) u0 (.*);

  task automatic check(bit ok, string req, string what, logic [63:0] act, logic [63:0] exp);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // One clock: combinational checks before the edge, state checks after it.
  task automatic step(string req);
    logic [2:0] m;
    #1;
    check(bus_addr == pri_addr && bus_wdata == pri_wdata && bus_ctrl == pri_ctrl && bus_we == pri_we,
          "R1", "bus forward", {bus_addr, bus_wdata}, {pri_addr, pri_wdata});
    check(pri_rdata == bus_rdata && shd_rdata == bus_rdata && pri_ready == bus_ready && shd_ready == bus_ready,
          "R2", "read fanout", {pri_rdata, shd_rdata}, {bus_rdata, bus_rdata});
    check(fault == m_fault, "R10", "fault before edge", fault, m_fault);
    m[0] = (pri_addr ^ {31'b0, inject}) != shd_addr;
    m[1] = pri_we && (pri_wdata != shd_wdata);
    m[2] = {pri_we, pri_ctrl} != {shd_we, shd_ctrl};
    @(posedge clk);
    if (!rst_n) begin
      m_fault = 0; m_grp = 0;
    end else begin
      if (!m_fault && m != 0) m_grp = m;
      if (m != 0) m_fault = 1;
    end
    #1;
    check(fault == m_fault, req, "fault", fault, m_fault);
    check(fault_grp == m_grp, req, "fault_grp", fault_grp, m_grp);
    @(negedge clk);
  endtask

  task automatic agree();
    pri_addr = $urandom; pri_wdata = $urandom; pri_ctrl = 4'($urandom);
    pri_we = 1'($urandom); bus_rdata = $urandom; bus_ready = 1'($urandom);
    shd_addr = pri_addr; shd_wdata = pri_wdata; shd_ctrl = pri_ctrl; shd_we = pri_we;
    inject = 0;
  endtask

  task automatic do_reset();
    agree();
    rst_n = 0;
    for (int i = 0; i < 3; i++) step("R9");
    rst_n = 1;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      fails++;
      $display("FAIL watchdog: actual %0d expected <20000", cycles);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    do_reset();
    // R1 R2: matching random traffic, no fault
    for (int i = 0; i < 30; i++) begin agree(); step("R1"); end
    // R3: top address bit differs, then R6 stays after agreement
    agree(); shd_addr = pri_addr ^ 32'h8000_0000; step("R3");
    for (int i = 0; i < 4; i++) begin agree(); step("R6"); end
    // R7: later control mismatch does not alter status
    agree(); shd_ctrl = ~pri_ctrl; step("R7");

    // R4: data differs without write -> ignored; with write -> data group
    do_reset();
    for (int i = 0; i < 5; i++) begin
      agree(); pri_we = 0; shd_we = 0; shd_wdata = ~pri_wdata; step("R4");
    end
    agree(); pri_we = 1; shd_we = 1; shd_wdata = pri_wdata ^ 32'h1; step("R4");

    // R5: write enable differs only
    do_reset();
    agree(); shd_we = ~pri_we; step("R5");
    do_reset();
    agree(); shd_ctrl = pri_ctrl ^ 4'h8; step("R5");

    // R8: injection on agreeing cores
    do_reset();
    agree(); inject = 1; step("R8");
    agree(); step("R8");

    // R7: two groups in the first faulting cycle
    do_reset();
    agree(); shd_addr = pri_addr ^ 32'h10; shd_ctrl = pri_ctrl ^ 4'h1; step("R7");

    // R9: reset clears a raised fault
    do_reset();
    for (int i = 0; i < 20; i++) begin agree(); step("R9"); end

    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule